// File: doc/BRIEF.md
# Masked Time Alarm Comparator

This block watches a running clock-calendar and raises an alarm when the current time agrees with a programmed alarm time. Four alarm registers hold BCD targets for seconds, minutes, hours and day. A mask bit in each register removes that field from the comparison. In the day register, a selector bit chooses whether the target is the day of the week or the day of the month.

The surrounding timekeeper supplies the current BCD fields and pulses a one-second strobe once the fields hold their new values. On that strobe the block compares the fields with the alarm registers. A full match sets a sticky alarm flag. The host reads the flag through control register A, and that read clears it. When the alarm enable bit in control register B is set, the flag drives an active-low interrupt pin.

Top module: `alarm_cmp`

## Requirements
- R1: After reset the alarm flag is 0, irq_n is 1, the enable bit is 0, and all four alarm registers and both control registers read back as 8'h00.
- R2: The alarm registers are at addresses 08h (seconds), 09h (minutes), 0Ah (hours) and 0Bh (day). A read returns the last value written, except that bit 6 of the hours register always reads 0. A read of an unmapped address returns 8'h00.
- R3: When a tick arrives and every unmasked field equals its alarm value, the alarm flag is 1 from the next clock edge.
- R4: Bit 7 of each alarm register is the mask for that field. A masked field always counts as matching, so with all four masks set every tick sets the flag.
- R5: In the day register (0Bh), bit 6 = 1 compares bits 5:0 with the day-of-week input. Bit 6 = 0 compares them with the date input.
- R6: No comparison happens without a tick. Fields that match while tick is 0 leave the flag unchanged.
- R7: A read of address 0Eh returns the flag in bit 0, with bits 7:1 as 0, on the cycle after the read. The read clears the flag. If a matching tick arrives in the same cycle as that read, the flag stays 1.
- R8: Bit 3 of control register B (0Fh) is the alarm enable. It reads back as written, and its other bits read 0. irq_n is 0 exactly when both the flag and the enable are 1.
- R9: A tick where any unmasked field differs from its alarm value leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe; the time fields are valid while it is high |
| cur_sec | input | 8 | Current BCD seconds |
| cur_min | input | 8 | Current BCD minutes |
| cur_hour | input | 8 | Current BCD hours, 24-hour format |
| cur_wday | input | 8 | Current day of week, 1 to 7 |
| cur_mday | input | 8 | Current BCD date, 01 to 31 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered; valid the cycle after rd_en |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A corrupted alarm register or mask bit shows up at the first tick that should fire: the flag either fails to rise or rises when it should not, one cycle after that tick. The same wrong value is also visible on the next bus read of that register. A flag that fails to clear, or that clears on the wrong access, shows on irq_n and on the next read of 0Eh in the cycle after the access. The bench checks every tick result and every read one cycle after the stimulus.

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 5'h08,
  parameter logic [ADDR_W-1:0] CTRLA_ADR = 5'h0E,
  parameter logic [ADDR_W-1:0] CTRLB_ADR = 5'h0F,
  parameter int IE_BIT     = 3,
  parameter int NFIELD     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_wday,
  input  logic [7:0]        cur_mday,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              alarm_flag,
  output logic              irq_n
);

  localparam int HR_IDX  = 2;
  localparam int DAY_IDX = NFIELD - 1;

  logic [7:0]        alm [NFIELD];
  logic [7:0]        cur [NFIELD];
  logic [7:0]        keep [NFIELD];
  logic [NFIELD-1:0] mask_bits;
  logic [NFIELD-1:0] fld_hit;
  logic              irq_en;
  logic              hit;
  logic              flag_rd;
  logic [7:0]        rd_mux;

  assign cur[0] = cur_sec;
  assign cur[1] = cur_min;
  assign cur[2] = cur_hour;
  assign cur[3] = alm[DAY_IDX][6] ? cur_wday : cur_mday;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam logic [7:0] KEEP_M = (i >= HR_IDX) ? 8'h3F : 8'h7F;
    assign keep[i]      = KEEP_M;
    assign mask_bits[i] = alm[i][7];
    assign fld_hit[i]   = mask_bits[i] | ((alm[i] & KEEP_M) == cur[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alm[i] <= '0;
      else if (wr_en && addr == ALM_BASE + ADDR_W'(i))
        alm[i] <= (i == HR_IDX) ? (wdata & 8'hBF) : wdata;
    end
  end

  assign hit     = tick & (&fld_hit);
  assign flag_rd = rd_en && addr == CTRLA_ADR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm_flag <= 1'b0;
    else if (hit)
      alarm_flag <= 1'b1;
    else if (flag_rd)
      alarm_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_en <= 1'b0;
    else if (wr_en && addr == CTRLB_ADR)
      irq_en <= wdata[IE_BIT];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NFIELD; i++)
      if (addr == ALM_BASE + ADDR_W'(i)) rd_mux = alm[i];
    if (addr == CTRLA_ADR) rd_mux = {7'd0, alarm_flag};
    if (addr == CTRLB_ADR) rd_mux[IE_BIT] = irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  assign irq_n = ~(alarm_flag & irq_en);

  logic unused_keep;
  assign unused_keep = ^{keep[0], keep[1], keep[2], keep[3]};

endmodule

module alarm_cmp_chk #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRLA_ADR = 5'h0E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              alarm_flag,
  input logic              irq_n,
  input logic              irq_en,
  input logic [3:0]        mask_bits
);
  a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick));
  a_r4_all_masked_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && &mask_bits) |=> alarm_flag);
  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(rd_en && addr == CTRLA_ADR)) |=> $stable(alarm_flag));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && rd_en && addr == CTRLA_ADR) |=> !alarm_flag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (alarm_flag && irq_en));
  a_r8_irq_when_both: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && irq_en) |-> !irq_n);
endmodule

bind alarm_cmp alarm_cmp_chk #(.ADDR_W(ADDR_W), .CTRLA_ADR(CTRLA_ADR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .addr(addr),
  .alarm_flag(alarm_flag), .irq_n(irq_n), .irq_en(irq_en), .mask_bits(mask_bits)
);

// File: tb/alarm_cmp_bench.sv
module alarm_cmp_bench;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_wday = 0, cur_mday = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic alarm_flag, irq_n;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic pend = 0;

  always #2.5 clk = ~clk;

  alarm_cmp u_alarm_cmp (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) if (pend) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    chk(t, rdata, e);
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, md);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = wd; cur_mday = md;
  endtask

  task automatic do_tick(input logic [7:0] s, m, h, wd, md);
    @(negedge clk); set_time(s, m, h, wd, md); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flag", {7'd0, alarm_flag}, 8'd0);
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    rst_n = 1;
    for (int i = 8; i < 12; i++) rd(5'(i), 8'h00, "R1 alarm reg");
    rd(5'h0E, 8'h00, "R1 ctrl A");
    rd(5'h0F, 8'h00, "R1 ctrl B");

    wr(5'h08, 8'h30); wr(5'h09, 8'h15); wr(5'h0A, 8'h7F); wr(5'h0B, 8'h25);
    rd(5'h08, 8'h30, "R2 sec");
    rd(5'h09, 8'h15, "R2 min");
    rd(5'h0A, 8'h3F, "R2 hour bit6");
    rd(5'h0B, 8'h25, "R2 day");
    rd(5'h13, 8'h00, "R2 unmapped");
    wr(5'h0A, 8'h12);

    @(negedge clk); set_time(8'h30, 8'h15, 8'h12, 8'h03, 8'h25);
    repeat (2) @(negedge clk);
    chk("R6 no tick", {7'd0, alarm_flag}, 8'd0);

    do_tick(8'h31, 8'h15, 8'h12, 8'h03, 8'h25);
    chk("R9 sec miss", {7'd0, alarm_flag}, 8'd0);
    do_tick(8'h30, 8'h15, 8'h13, 8'h03, 8'h25);
    chk("R9 hour miss", {7'd0, alarm_flag}, 8'd0);

    do_tick(8'h30, 8'h15, 8'h12, 8'h03, 8'h25);
    chk("R3 match", {7'd0, alarm_flag}, 8'd1);
    chk("R8 irq off while disabled", {7'd0, irq_n}, 8'd1);
    rd(5'h0E, 8'h01, "R7 read flag");
    chk("R7 cleared", {7'd0, alarm_flag}, 8'd0);
    rd(5'h0E, 8'h00, "R7 second read");

    wr(5'h0F, 8'hFF);
    rd(5'h0F, 8'h08, "R8 enable readback");
    do_tick(8'h30, 8'h15, 8'h12, 8'h03, 8'h25);
    chk("R8 irq asserted", {7'd0, irq_n}, 8'd0);
    rd(5'h0E, 8'h01, "R8 read");
    chk("R8 irq released", {7'd0, irq_n}, 8'd1);

    wr(5'h08, 8'h80);
    do_tick(8'h47, 8'h15, 8'h12, 8'h03, 8'h25);
    chk("R4 sec masked", {7'd0, alarm_flag}, 8'd1);
    rd(5'h0E, 8'h01, "R4 read");

    wr(5'h0B, 8'h45);
    do_tick(8'h00, 8'h15, 8'h12, 8'h05, 8'h09);
    chk("R5 weekday match", {7'd0, alarm_flag}, 8'd1);
    rd(5'h0E, 8'h01, "R5 read");
    do_tick(8'h00, 8'h15, 8'h12, 8'h03, 8'h05);
    chk("R5 date ignored", {7'd0, alarm_flag}, 8'd0);
    wr(5'h0B, 8'h05);
    do_tick(8'h00, 8'h15, 8'h12, 8'h03, 8'h05);
    chk("R5 date match", {7'd0, alarm_flag}, 8'd1);
    rd(5'h0E, 8'h01, "R5 read2");

    wr(5'h09, 8'h80); wr(5'h0A, 8'h80); wr(5'h0B, 8'h80);
    for (int k = 0; k < 3; k++) begin
      do_tick(8'(k * 7), 8'h59, 8'h23, 8'h07, 8'h31);
      chk("R4 all masked", {7'd0, alarm_flag}, 8'd1);
      rd(5'h0E, 8'h01, "R4 all masked read");
    end

    @(negedge clk);
    rd_en = 1; addr = 5'h0E; tick = 1; set_time(8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
    exp_q.push_back(8'h00); tag_q.push_back("R7 collide read");
    @(negedge clk); rd_en = 0; tick = 0;
    chk("R7 set wins", {7'd0, alarm_flag}, 8'd1);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule